// File: doc/BRIEF.md
# Packed Signed Word Multiplier with Pairwise Accumulate

This block multiplies two 64-bit packed operands lane by lane. Each operand holds four signed 16-bit lanes. The four lane products are formed in full 32-bit precision in a first register stage. A second stage then turns them into the requested result:

- the bottom half of every product, packed into four 16-bit lanes;
- the top half of every product, packed into four 16-bit lanes;
- two 32-bit sums, each built from a neighbouring pair of products.

The block is a plain two-stage pipeline for the datapath of a media engine. A caller presents an operation code, the two operands and `in_valid`. The matching result leaves on `out_data`, marked by `out_valid`, exactly two clock edges later.

There is no ready signal in either direction. The block never stalls, and it takes a new operation on every clock. The consumer must accept each result in the cycle it is flagged, because the block holds no backlog.

Top module: `pmul_unit`

## Requirements
- R1: Every lane pair `in_a[16i+15:16i]`, `in_b[16i+15:16i]` (i = 0..3) is multiplied as signed two's complement, giving a full 32-bit product P_i.
- R2: With `in_op` = 0, `out_data[16i+15:16i]` equals bits 15:0 of P_i for every lane i.
- R3: With `in_op` = 1, `out_data[16i+15:16i]` equals bits 31:16 of P_i for every lane i.
- R4: With `in_op` = 2, `out_data[31:0]` equals (P_0 + P_1) mod 2^32 and `out_data[63:32]` equals (P_2 + P_3) mod 2^32.
- R5: With `in_op` = 2 and all four 16-bit lanes of both operands equal to 0x8000, each 32-bit half of the result is 0x80000000.
- R6: With `in_op` = 3, the result is all zeros.
- R7: An operation accepted at clock edge k appears on `out_data` with `out_valid` high in the cycle after edge k+1. `out_valid` is high only in such cycles.
- R8: A new operation is accepted on every clock edge. Back-to-back operations each yield their own result, in issue order, with none lost.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `out_data` go to zero at that edge.
- R10: `out_data` keeps its last value in every cycle where `out_valid` is low.
- R11: If either operand of an accepted operation is all zeros, its result is all zeros for every `in_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | 0 low halves, 1 high halves, 2 pairwise sum, 3 zero |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Packed result |

## Verification
The main sweep runs each operation code over every pairing drawn from a set of eight lane values: 0, ±1, ±2, 0x7FFF, 0x8000 and a mixed pattern. The sweep rotates the values so that each lane meets a different partner.

- Sign handling shows up in the high-half results, which split signed from unsigned multiplication.
- The extreme values exercise wrap-around in the pairwise sums.
- Zero operands separate a truly cleared result from a stale one.

A pseudo-random stream with idle gaps follows. It tells apart correct result ordering and timing from results that slip a cycle, and it confirms that the output holds while idle. A dedicated all-0x8000 case probes the one sum that cannot be represented.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [1:0] {
    PM_LOW  = 2'd0,
    PM_HIGH = 2'd1,
    PM_MADD = 2'd2,
    PM_ZERO = 2'd3
  } pm_op_e;

endpackage

// File: rtl/pmul_lane_mult.sv
module pmul_lane_mult #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0]   a,
  input  logic [LANE_W-1:0]   b,
  output logic [2*LANE_W-1:0] p
);
  localparam int PROD_W = 2 * LANE_W;

  logic signed [PROD_W-1:0] prod;

  // signed operands are sign-extended to the product width
  assign prod = $signed(a) * $signed(b);
  assign p    = prod;
endmodule

// File: rtl/pmul_stage_mult.sv
module pmul_stage_mult
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  pm_op_e                     in_op,
  input  logic [LANES*LANE_W-1:0]    in_a,
  input  logic [LANES*LANE_W-1:0]    in_b,
  output logic                       s1_valid,
  output pm_op_e                     s1_op,
  output logic [LANES*2*LANE_W-1:0]  s1_prod
);
  localparam int PROD_W = 2 * LANE_W;

  logic [LANES*PROD_W-1:0] prod_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pmul_lane_mult #(.LANE_W(LANE_W)) u_mult (
      .a (in_a[g*LANE_W +: LANE_W]),
      .b (in_b[g*LANE_W +: LANE_W]),
      .p (prod_c[g*PROD_W +: PROD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= PM_ZERO;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op   <= in_op;
        s1_prod <= prod_c;
      end
    end
  end
endmodule

// File: rtl/pmul_stage_combine.sv
module pmul_stage_combine
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_valid,
  input  pm_op_e                     s1_op,
  input  logic [LANES*2*LANE_W-1:0]  s1_prod,
  output logic                       out_valid,
  output logic [LANES*LANE_W-1:0]    out_data
);
  localparam int PROD_W = 2 * LANE_W;
  localparam int DATA_W = LANES * LANE_W;
  localparam int PAIRS  = LANES / 2;

  logic [DATA_W-1:0] low_w;
  logic [DATA_W-1:0] high_w;
  logic [DATA_W-1:0] madd_w;
  logic [DATA_W-1:0] sel_c;

  for (genvar g = 0; g < LANES; g++) begin : g_half
    assign low_w[g*LANE_W +: LANE_W]  = s1_prod[g*PROD_W +: LANE_W];
    assign high_w[g*LANE_W +: LANE_W] = s1_prod[g*PROD_W + LANE_W +: LANE_W];
  end

  // each pair of neighbouring products fills one double-width lane
  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign madd_w[j*PROD_W +: PROD_W] =
      s1_prod[(2*j)*PROD_W +: PROD_W] + s1_prod[(2*j+1)*PROD_W +: PROD_W];
  end

  always_comb begin
    unique case (s1_op)
      PM_LOW:  sel_c = low_w;
      PM_HIGH: sel_c = high_w;
      PM_MADD: sel_c = madd_w;
      default: sel_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= sel_c;
    end
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_op,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int PROD_W = 2 * LANE_W;

  logic                    s1_valid;
  pm_op_e                  s1_op;
  logic [LANES*PROD_W-1:0] s1_prod;
  pm_op_e                  op_e;

  assign op_e = pm_op_e'(in_op);

  pmul_stage_mult #(.LANES(LANES), .LANE_W(LANE_W)) u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (op_e),
    .in_a     (in_a),
    .in_b     (in_b),
    .s1_valid (s1_valid),
    .s1_op    (s1_op),
    .s1_prod  (s1_prod)
  );

  pmul_stage_combine #(.LANES(LANES), .LANE_W(LANE_W)) u_comb (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_op     (s1_op),
    .s1_prod   (s1_prod),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              in_op,
  input logic [LANES*LANE_W-1:0] in_a,
  input logic [LANES*LANE_W-1:0] in_b,
  input logic                    out_valid,
  input logic [LANES*LANE_W-1:0] out_data
);
  localparam int DATA_W = LANES * LANE_W;

  logic v1, v2, z1, z2, r1, r2, c1, c2;
  logic zero_in, rsvd_in, corner_in;

  assign zero_in   = in_valid && ((in_a == '0) || (in_b == '0));
  assign rsvd_in   = in_valid && (in_op == 2'd3);
  assign corner_in = in_valid && (in_op == 2'd2) &&
                     (in_a[31:0] == 32'h8000_8000) && (in_b[31:0] == 32'h8000_8000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, v2, z1, z2, r1, r2, c1, c2} <= '0;
    end else begin
      v1 <= in_valid;  v2 <= v1;
      z1 <= zero_in;   z2 <= z1;
      r1 <= rsvd_in;   r2 <= r1;
      c1 <= corner_in; c2 <= c1;
    end
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v2);

  a_r6_zero_op: assert property (@(posedge clk) disable iff (!rst_n)
    r2 |-> out_data == {DATA_W{1'b0}});

  a_r11_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    z2 |-> out_data == {DATA_W{1'b0}});

  a_r5_corner: assert property (@(posedge clk) disable iff (!rst_n)
    c2 |-> out_data[31:0] == 32'h8000_0000);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r9_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == {DATA_W{1'b0}}));
endmodule

bind pmul_unit pmul_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/pmul_unit_test.sv
module pmul_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int issued = 0;
  int received = 0;
  logic [63:0] last_out = '0;
  logic [63:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pmul_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(input logic [1:0] op,
                                        input logic [63:0] a, input logic [63:0] b);
    logic signed [31:0] p [4];
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) p[i] = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]);
    case (op)
      2'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
      2'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
      2'd2: begin r[31:0] = p[0] + p[1]; r[63:32] = p[2] + p[3]; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0: return "R2";
      2'd1: return "R3 R1";
      2'd2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic observe();
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        int c;
        string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        received++;
        check(out_data == e, t, out_data, e);
        check(cyc == c + 2, "R7 latency", 64'(cyc - c), 64'd2);
      end
    end else begin
      if (exp_q.size() != 0 && cyc_q[0] + 2 <= cyc)
        check(0, "R7 missing result", 64'd0, 64'd1);
      check(out_data == last_out, "R10 hold while idle", out_data, last_out);
    end
    last_out = out_data;
  endtask

  task automatic step(input logic v, input logic [1:0] op,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    @(negedge clk);
    cyc++;
    observe();
    in_valid = v; in_op = op; in_a = a; in_b = b;
    if (v) begin
      exp_q.push_back(model(op, a, b));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
      issued++;
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
             16'h8000, 16'h0002, 16'hFFFE, 16'h1234};

    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9 out_valid in reset", 64'(out_valid), 64'd0);
    check(out_data == '0, "R9 out_data in reset", out_data, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    last_out = out_data;

    // back-to-back sweep (R8): every op, every pairing of lane values
    for (int op = 0; op < 4; op++)
      for (int x = 0; x < 8; x++)
        for (int y = 0; y < 8; y++) begin
          logic [63:0] a, b;
          for (int i = 0; i < 4; i++) begin
            a[16*i +: 16] = vals[(x + i) % 8];
            b[16*i +: 16] = vals[(y + 3*i) % 8];
          end
          step(1'b1, op[1:0], a, b, op_tag(op[1:0]));
        end

    // R11 zero operand against each op
    for (int op = 0; op < 4; op++)
      step(1'b1, op[1:0], 64'd0, 64'hDEAD_BEEF_8000_7FFF, "R11");

    // R5 unrepresentable pairwise sum
    step(1'b1, 2'd2, {4{16'h8000}}, {4{16'h8000}}, "R5");
    step(1'b0, 2'd0, '0, '0, "");
    step(1'b0, 2'd0, '0, '0, "");
    step(1'b0, 2'd0, '0, '0, "");

    // pseudo-random stream with idle gaps (R8 R10)
    for (int k = 0; k < 600; k++) begin
      logic [63:0] a, b;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a[31:0] = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a[63:32] = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      b[31:0] = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      b[63:32] = lfsr;
      step(lfsr[3] | lfsr[7], lfsr[1:0], a, b, op_tag(lfsr[1:0]));
    end

    for (int k = 0; k < 5; k++) step(1'b0, 2'd0, '0, '0, "");

    // R8 every issued operation produced exactly one result
    check(received == issued, "R8 results vs issued", 64'(received), 64'(issued));
    done = 1;
    report();
    $finish;
  end
endmodule